// File: doc/BRIEF.md
# ALU Flag and Branch-Condition Unit

This block is the flag half of a 32-bit integer datapath. Each cycle it forms a combinational result from two operands: add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR or NOT. When the flag-write strobe is high, it also updates the negative, zero, overflow and carry flags held in a 32-bit status word. The carry flag holds a borrow directly after a subtraction, so unsigned comparisons need no inversion.

The status word also keeps a dividend-sign bit and a 4-bit interrupt level. These are written only through an explicit status-load operation. A sticky multiply-accumulate overflow bit is set by a one-cycle event input and stays set until a status load clears it or reset occurs.

A 4-bit selector picks one of ten branch tests, which are evaluated from the registered flags. The tests are signed greater/greater-equal/less/less-equal, their unsigned counterparts, equal and not-equal. The branch-taken output is combinational from the current flags, so a compare issued in one cycle decides a branch in the next.

Top module: `alu_flag_unit`

## Requirements
- R1: The result equals a+b (ADD, op 0), a-b (SUB, op 2), a-b (CMP, op 4), a&b (AND, op 5), a|b (OR, op 6), a^b (XOR, op 7) or ~b (NOT, op 8). Every other code, including status load (op 9), gives 0. With flag_we high, an arithmetic or logic op copies result bit 31 into N (status bit 0) and sets Z (status bit 1) exactly when the 32-bit result is zero.
- R2: With flag_we high after ADD, ADC, SUB, SBC or CMP, V (status bit 2) is set exactly when a signed overflow occurs. For addition, that means both operands have the same sign and the result sign differs. For subtraction, it means the operand signs differ and the result sign differs from a.
- R3: With flag_we high, C (status bit 3) is set when an addition's true sum exceeds 0xFFFFFFFF, and when a subtraction or compare borrows, that is, when its true difference is below zero.
- R4: ADC (op 1) computes a+b+C and SBC (op 3) computes a-b-C, where C is the carry flag before the op. The carry term is used for both the result and the new N, Z, V and C.
- R5: Logic ops (5 to 8) leave V and C unchanged.
- R6: res_wr is high exactly when flag_we is high and the op is ADD, ADC, SUB, SBC or one of the logic ops. CMP updates flags like SUB but keeps res_wr low.
- R7: A high mac_ovf sets MO (status bit 7) at the next edge, whatever flag_we is. MO then stays set until a status load with flag_we high writes it, and a coincident mac_ovf wins over that write.
- R8: Status load (op 9, flag_we high) copies operand b bits 3:0, 6, 7 and 11:8 into N/Z/V/C, DS (bit 6), MO (bit 7) and IL (bits 11:8). Status bits 5:4 and 31:12 always read 0.
- R9: After reset every status bit is 0.
- R10: br_taken for cond_sel 0 to 3 is gt = !Z&!(N^V), ge = !(N^V), lt = N^V and le = Z|(N^V).
- R11: br_taken for cond_sel 4 to 9 is ugt = !Z&!C, uge = !C, ult = C, ule = Z|C, eq = Z and ne = !Z. cond_sel 10 to 15 give 0.
- R12: With flag_we low, N, Z, V, C, DS and IL keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, also the status-load source |
| op_code | input | 4 | Operation select |
| flag_we | input | 1 | Commit flags (and result write) this cycle |
| mac_ovf | input | 1 | Multiply-accumulate overflow event |
| cond_sel | input | 4 | Branch test select |
| result | output | 32 | Combinational result |
| res_wr | output | 1 | Result should be written to a register |
| status | output | 32 | Status word |
| br_taken | output | 1 | Selected branch test outcome |

## Verification
The bench drives signed boundaries such as 0x7FFFFFFF+1, 0x80000000+0x80000000, 0x80000000-1 and 0x7FFFFFFF-0xFFFFFFFF. A design that derived V from the carry out, or inverted the borrow, would mis-flag these. Add-with-carry and subtract-with-borrow are run with C both set and clear, which exposes a carry input that feeds the result but not the flags. MO is set, then held through ordinary ops and a status load that tries to clear it in the same cycle as an event; a non-sticky or write-priority flag drops it there. All ten branch tests, plus the unused selectors, are compared each cycle against formulas written in the bench.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [3:0]    op_code,
  input  logic          flag_we,
  input  logic          mac_ovf,
  input  logic [3:0]    cond_sel,
  output logic [DW-1:0] result,
  output logic          res_wr,
  output logic [31:0]   status,
  output logic          br_taken
);
  localparam int MSB = DW - 1;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
                         OP_NOT = 4'd8, OP_LDS = 4'd9;

  logic       f_n, f_z, f_v, f_c, f_ds, f_mo;
  logic [3:0] f_il;

  logic          cin, is_add, is_sub, is_logic;
  logic [DW:0]   add_w, sub_w;
  logic          v_add, v_sub;

  assign is_add   = (op_code == OP_ADD) || (op_code == OP_ADC);
  assign is_sub   = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_CMP);
  assign is_logic = (op_code >= OP_AND) && (op_code <= OP_NOT);
  assign cin      = ((op_code == OP_ADC) || (op_code == OP_SBC)) ? f_c : 1'b0;

  assign add_w = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, cin};
  assign sub_w = {1'b0, opnd_a} - {1'b0, opnd_b} - {{DW{1'b0}}, cin};
  assign v_add = (opnd_a[MSB] == opnd_b[MSB]) && (add_w[MSB] != opnd_a[MSB]);
  assign v_sub = (opnd_a[MSB] != opnd_b[MSB]) && (sub_w[MSB] != opnd_a[MSB]);

  always_comb begin
    case (op_code)
      OP_ADD, OP_ADC:         result = add_w[MSB:0];
      OP_SUB, OP_SBC, OP_CMP: result = sub_w[MSB:0];
      OP_AND:                 result = opnd_a & opnd_b;
      OP_OR:                  result = opnd_a | opnd_b;
      OP_XOR:                 result = opnd_a ^ opnd_b;
      OP_NOT:                 result = ~opnd_b;
      default:                result = '0;
    endcase
  end

  assign res_wr = flag_we && (is_add || is_logic || (is_sub && op_code != OP_CMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_n <= 1'b0; f_z <= 1'b0; f_v <= 1'b0; f_c <= 1'b0;
      f_ds <= 1'b0; f_mo <= 1'b0; f_il <= 4'd0;
    end else begin
      if (flag_we) begin
        if (is_add || is_sub || is_logic) begin
          f_n <= result[MSB];
          f_z <= (result == '0);
        end
        if (is_add) begin
          f_v <= v_add;
          f_c <= add_w[DW];
        end else if (is_sub) begin
          f_v <= v_sub;
          f_c <= sub_w[DW];
        end
        if (op_code == OP_LDS) begin
          f_n  <= opnd_b[0];
          f_z  <= opnd_b[1];
          f_v  <= opnd_b[2];
          f_c  <= opnd_b[3];
          f_ds <= opnd_b[6];
          f_il <= opnd_b[11:8];
        end
      end
      if (mac_ovf)
        f_mo <= 1'b1;
      else if (flag_we && op_code == OP_LDS)
        f_mo <= opnd_b[7];
    end
  end

  assign status = {20'd0, f_il, f_mo, f_ds, 2'b00, f_c, f_v, f_z, f_n};

  logic sgn_lt;
  assign sgn_lt = f_n ^ f_v;

  always_comb begin
    case (cond_sel)
      4'd0:    br_taken = !f_z && !sgn_lt;
      4'd1:    br_taken = !sgn_lt;
      4'd2:    br_taken = sgn_lt;
      4'd3:    br_taken = f_z || sgn_lt;
      4'd4:    br_taken = !f_z && !f_c;
      4'd5:    br_taken = !f_c;
      4'd6:    br_taken = f_c;
      4'd7:    br_taken = f_z || f_c;
      4'd8:    br_taken = f_z;
      4'd9:    br_taken = !f_z;
      default: br_taken = 1'b0;
    endcase
  end

  p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (is_add || is_sub || is_logic)) |=> (status[1] == ($past(result) == '0)));

  p_sign_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (is_add || is_sub || is_logic)) |=> (status[0] == $past(result[MSB])));

  p_logic_keeps_vc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic) |=> $stable(status[3:2]));

  p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP) |-> !res_wr);

  p_mo_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mac_ovf |=> status[7]);

  p_mo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !(flag_we && op_code == OP_LDS)) |=> status[7]);

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:12] == 20'd0) && (status[5:4] == 2'b00));

  p_hold_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> ($stable(status[3:0]) && $stable(status[6]) && $stable(status[11:8])));

  p_eq_test_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd8) |-> (br_taken == status[1]));
endmodule

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  op_code = '0, cond_sel = '0;
  logic        flag_we = 1'b0, mac_ovf = 1'b0;
  logic [31:0] result, status;
  logic        res_wr, br_taken;

  int n_checks = 0, n_fail = 0;
  logic m_n, m_z, m_v, m_c, m_ds, m_mo;
  logic [3:0] m_il;

  always #2.5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
    .flag_we(flag_we), .mac_ovf(mac_ovf), .cond_sel(cond_sel), .result(result),
    .res_wr(res_wr), .status(status), .br_taken(br_taken));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic cond_exp(logic [3:0] s);
    case (s)
      4'd0: return !m_z && !(m_n ^ m_v);
      4'd1: return !(m_n ^ m_v);
      4'd2: return m_n ^ m_v;
      4'd3: return m_z || (m_n ^ m_v);
      4'd4: return !m_z && !m_c;
      4'd5: return !m_c;
      4'd6: return m_c;
      4'd7: return m_z || m_c;
      4'd8: return m_z;
      4'd9: return !m_z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_status();
    return {20'd0, m_il, m_mo, m_ds, 2'b00, m_c, m_v, m_z, m_n};
  endfunction

  task automatic step(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                      logic we, logic mac, logic [3:0] cs);
    logic [32:0] wide;
    logic [31:0] er;
    logic cin, ew, arith, nv, nc;
    string tr, tv, tc, tb;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; flag_we = we; mac_ovf = mac; cond_sel = cs;
    #1;
    cin = (op == 4'd1 || op == 4'd3) ? m_c : 1'b0;
    arith = (op <= 4'd4);
    nv = m_v; nc = m_c; er = 32'd0;
    if (op == 4'd0 || op == 4'd1) begin
      wide = {1'b0, a} + {1'b0, b} + {32'd0, cin};
      er = wide[31:0]; nc = wide[32];
      nv = (a[31] == b[31]) && (er[31] != a[31]);
    end else if (arith) begin
      wide = {1'b0, a} - {1'b0, b} - {32'd0, cin};
      er = wide[31:0]; nc = wide[32];
      nv = (a[31] != b[31]) && (er[31] != a[31]);
    end else if (op == 4'd5) er = a & b;
    else if (op == 4'd6) er = a | b;
    else if (op == 4'd7) er = a ^ b;
    else if (op == 4'd8) er = ~b;
    ew = we && op <= 4'd8 && op != 4'd4;
    tr = (op == 4'd1 || op == 4'd3) ? "R4" : "R1";
    chk({tr, " result"}, result, er);
    chk("R6 res_wr", {31'd0, res_wr}, {31'd0, ew});
    chk(cs <= 4'd3 ? "R10 branch" : "R11 branch", {31'd0, br_taken}, {31'd0, cond_exp(cs)});
    if (we && op <= 4'd8) begin
      m_n = er[31]; m_z = (er == 32'd0);
      if (arith) begin m_v = nv; m_c = nc; end
    end else if (we && op == 4'd9) begin
      {m_c, m_v, m_z, m_n} = b[3:0]; m_ds = b[6]; m_il = b[11:8]; m_mo = b[7];
    end
    if (mac) m_mo = 1'b1;
    tb = !we ? "R12" : (op == 4'd9) ? "R8" : tr;
    tv = !we ? "R12" : (op >= 4'd5 && op <= 4'd8) ? "R5" : (op == 4'd9) ? "R8" :
         (op == 4'd1 || op == 4'd3) ? "R4" : "R2";
    tc = (tv == "R2") ? "R3" : tv;
    @(posedge clk); #1;
    chk({tb, " N/Z"}, {30'd0, status[1:0]}, {30'd0, m_z, m_n});
    chk({tv, " V"}, {31'd0, status[2]}, {31'd0, m_v});
    chk({tc, " C"}, {31'd0, status[3]}, {31'd0, m_c});
    chk("R7 MO", {31'd0, status[7]}, {31'd0, m_mo});
    chk("R8 other bits", {status[31:8], 1'b0, status[6:4], 4'd0}, {m_status() & 32'hFFFF_FF70});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    {m_n, m_z, m_v, m_c, m_ds, m_mo} = '0; m_il = '0;
    repeat (3) @(posedge clk);
    #1 chk("R9 reset status", status, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R9 status after release", status, 32'd0);
    step(4'd0, 32'hFFFF_FFFF, 32'd1, 1, 0, 4'd8);
    step(4'd0, 32'h7FFF_FFFF, 32'd1, 1, 0, 4'd6);
    step(4'd0, 32'h8000_0000, 32'h8000_0000, 1, 0, 4'd2);
    step(4'd2, 32'd0, 32'd1, 1, 0, 4'd3);
    step(4'd2, 32'h8000_0000, 32'd1, 1, 0, 4'd6);
    step(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 0, 4'd2);
    step(4'd1, 32'd5, 32'd6, 1, 0, 4'd6);
    step(4'd3, 32'd5, 32'd4, 1, 0, 4'd4);
    step(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 4'd5);
    step(4'd1, 32'hFFFF_FFFF, 32'd0, 1, 0, 4'd7);
    step(4'd3, 32'd0, 32'd0, 1, 0, 4'd6);
    step(4'd5, 32'h0F0F_0000, 32'h00F0_0000, 1, 0, 4'd9);
    step(4'd4, 32'd3, 32'd3, 1, 0, 4'd0);
    step(4'd4, 32'd2, 32'd3, 1, 0, 4'd8);
    step(4'd0, 32'd9, 32'd9, 0, 1, 4'd1);
    step(4'd6, 32'd1, 32'd2, 1, 0, 4'd4);
    step(4'd9, 32'd0, 32'd0, 1, 1, 4'd12);
    step(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 4'd0);
    step(4'd9, 32'd0, 32'd0, 1, 0, 4'd15);
    step(4'd12, 32'd7, 32'd7, 1, 0, 4'd9);
    for (int i = 0; i < 3000; i++)
      step(4'($urandom % 11), pick(), pick(), ($urandom % 4) != 0,
           ($urandom % 16) == 0, 4'($urandom % 12));
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule